// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block combines four reset causes into one active-high system reset: a supply-low level from the power-on detector, a supply-low level from the brown-out detector, an external reset pin, and a one-cycle request from the watchdog. Both analog comparators sit outside the block. Their digital outputs are taken as already synchronous to `clk`. The external pin is asynchronous, so it passes through a synchronizer and then a qualification counter. This way a glitch of a single cycle cannot reset the chip.

A supply-low indication drives the reset output at once, through a combinational path, with no clock edge needed. When the supply comes back, a release counter for that source holds reset for a set number of clocks. Power-on and brown-out each have their own counter. A watchdog request turns into a reset pulse of fixed length. The reset output falls only at a clock edge.

The block also keeps a sticky cold-start flag that software can read. The flag is set by the power-on source only. Software clears it through a one-bit write port.

Top module: `rst_sequencer`

## Requirements
- R1: `sys_rst_o` is 1 whenever any source is active, and goes to 0 only when every source has become inactive.
- R2: While `por_low_i` is 1, `sys_rst_o` is 1 in the same cycle, before any clock edge.
- R3: After `por_low_i` returns to 0, power-on reset stays asserted for exactly POR_DELAY clock edges and then releases at a clock edge.
- R4: While `bod_low_i` is 1, `sys_rst_o` is 1 in the same cycle, before any clock edge.
- R5: After `bod_low_i` returns to 0, brown-out reset stays asserted for exactly BOD_DELAY clock edges.
- R6: An external pin level of 1, sampled on at least EXT_MIN (default 2) consecutive edges, asserts `sys_rst_o`. With the default 2-stage synchronizer, reset rises after the 4th edge from the first high sample. It falls 2 edges after the first low sample.
- R7: A pin pulse of 1 that is sampled on fewer than EXT_MIN edges leaves `sys_rst_o` at 0.
- R8: `wdt_req_i` high at an edge holds `sys_rst_o` at 1 for exactly WDT_PULSE (default 16) cycles after that edge. A new request during the pulse restarts the count.
- R9: `cold_flag_o` is 1 during and after `rst_n` reset, and is set at any edge where `por_low_i` is 1.
- R10: A write (`flag_wr_i`=1) with `flag_wdata_i`=0 clears `cold_flag_o` at that edge. A write of 1 has no effect. When `por_low_i`=1 at the same edge, the set wins.
- R11: The brown-out, pin and watchdog sources never change `cold_flag_o`.
- R12: From the release of `rst_n`, `sys_rst_o` stays 1 for max(POR_DELAY, BOD_DELAY) edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| por_low_i | input | 1 | Power-on detector: supply below threshold |
| bod_low_i | input | 1 | Brown-out detector: supply below trigger level |
| ext_rst_pin_i | input | 1 | External reset pin, active high, asynchronous |
| wdt_req_i | input | 1 | Watchdog reset request, one cycle |
| flag_wr_i | input | 1 | Write strobe for the cold-start flag |
| flag_wdata_i | input | 1 | Write data; 0 clears the flag |
| cold_flag_o | output | 1 | Sticky cold-start flag |
| sys_rst_o | output | 1 | Merged system reset, active high |

## Verification
The bench targets release timing at the exact edge for each supply channel. A counter that is off by one would release reset one cycle early or late, and the bench samples on both sides of that boundary. For the pin, it drives pulses one cycle and two cycles long. A filter without the qualification counter would reset on the short pulse, and one that is too strict would miss the two-cycle pulse. For the watchdog, it sends a request in the middle of a pulse; a stretcher that does not reload would end the pulse early. For the cold-start flag, it tries writes of 1, clears that collide with a power-on event, and the non-power sources. Any of these can wrongly set or clear the flag.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;

  // Number of supply-monitor channels handled by the sequencer.
  localparam int unsigned SUPPLY_CNT = 2;

  // Channel index of each supply monitor.
  typedef enum int unsigned {
    SUP_POR = 0,
    SUP_BOD = 1
  } supply_e;

  // Bits needed to hold values 0..maxval (never less than one bit).
  function automatic int unsigned width_for(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/rst_supply_hold.sv
`timescale 1ns/1ps
// One supply channel. The hold register is set while the comparator
// reports a low supply, then counts DELAY edges once the supply is good.
module rst_supply_hold #(
  parameter int unsigned DELAY = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_i,
  output logic hold_o
);
  import rst_seq_pkg::*;

  localparam int unsigned   CW   = width_for(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hold_q, hold_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    cnt_en = 1'b0;
    if (low_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
      hold_d = 1'b1;
    end else if (hold_q) begin
      cnt_en = 1'b1;
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        hold_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b1;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;

endmodule

// File: rtl/rst_pin_qual.sv
`timescale 1ns/1ps
// External pin: synchronizer chain followed by a run-length qualifier.
module rst_pin_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_CYC     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic active_o
);
  import rst_seq_pkg::*;

  localparam int unsigned   QW  = width_for(MIN_CYC - 1);
  localparam logic [QW-1:0] SAT = QW'(MIN_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   level;
  logic [QW-1:0]          run_q, run_d;
  logic                   run_en;
  logic                   act_q, act_d;

  assign sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
  assign level  = sync_q[SYNC_STAGES-1];

  always_comb begin
    run_d  = run_q;
    run_en = level | (run_q != '0);
    if (!level) begin
      run_d = '0;
    end else if (run_q != SAT) begin
      run_d = run_q + 1'b1;
    end
    act_d = level & (run_q == SAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (run_en) begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else begin
      act_q <= act_d;
    end
  end

  assign active_o = act_q;

endmodule

// File: rtl/rst_wdt_stretch.sv
`timescale 1ns/1ps
// Turns a one-cycle watchdog request into a reset pulse of PULSE cycles.
module rst_wdt_stretch #(
  parameter int unsigned PULSE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic active_o
);
  import rst_seq_pkg::*;

  localparam int unsigned   WW   = width_for(PULSE);
  localparam logic [WW-1:0] LOAD = WW'(PULSE);

  logic [WW-1:0] left_q, left_d;
  logic          left_en;

  always_comb begin
    left_d  = left_q;
    left_en = req_i | (left_q != '0);
    if (req_i) begin
      left_d = LOAD;
    end else if (left_q != '0) begin
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (left_en) begin
      left_q <= left_d;
    end
  end

  assign active_o = (left_q != '0);

endmodule

// File: rtl/rst_cold_flag.sv
`timescale 1ns/1ps
// Sticky cold-start flag: set by power-on, cleared only by writing 0.
module rst_cold_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic por_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic flag_o
);

  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = por_i | (wr_i & ~wdata_i);
    flag_d  = por_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b1;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/rst_sequencer.sv
`timescale 1ns/1ps
module rst_sequencer #(
  parameter int unsigned POR_DELAY   = 1024,
  parameter int unsigned BOD_DELAY   = 1024,
  parameter int unsigned EXT_SYNC    = 2,
  parameter int unsigned EXT_MIN     = 2,
  parameter int unsigned WDT_PULSE   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_low_i,
  input  logic bod_low_i,
  input  logic ext_rst_pin_i,
  input  logic wdt_req_i,
  input  logic flag_wr_i,
  input  logic flag_wdata_i,
  output logic cold_flag_o,
  output logic sys_rst_o
);
  import rst_seq_pkg::*;

  logic [SUPPLY_CNT-1:0] sup_low;
  logic [SUPPLY_CNT-1:0] sup_hold;
  logic                  ext_active;
  logic                  wdt_active;

  assign sup_low[SUP_POR] = por_low_i;
  assign sup_low[SUP_BOD] = bod_low_i;

  for (genvar g = 0; g < SUPPLY_CNT; g++) begin : g_supply
    localparam int unsigned CH_DELAY = (g == int'(SUP_POR)) ? POR_DELAY : BOD_DELAY;
    rst_supply_hold #(
      .DELAY (CH_DELAY)
    ) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .low_i  (sup_low[g]),
      .hold_o (sup_hold[g])
    );
  end

  rst_pin_qual #(
    .SYNC_STAGES (EXT_SYNC),
    .MIN_CYC     (EXT_MIN)
  ) u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (ext_rst_pin_i),
    .active_o (ext_active)
  );

  rst_wdt_stretch #(
    .PULSE (WDT_PULSE)
  ) u_wdt (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (wdt_req_i),
    .active_o (wdt_active)
  );

  rst_cold_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .por_i   (por_low_i),
    .wr_i    (flag_wr_i),
    .wdata_i (flag_wdata_i),
    .flag_o  (cold_flag_o)
  );

  // Supply-low levels reach the output combinationally; every other term
  // is a register, so release always happens at a clock edge.
  assign sys_rst_o = (|sup_low) | (|sup_hold) | ext_active | wdt_active;

endmodule

// File: rtl/rst_sequencer_chk.sv
`timescale 1ns/1ps
module rst_sequencer_chk #(
  parameter int unsigned POR_DELAY = 1024,
  parameter int unsigned BOD_DELAY = 1024,
  parameter int unsigned WDT_PULSE = 16
) (
  input logic clk,
  input logic rst_n,
  input logic por_low_i,
  input logic bod_low_i,
  input logic wdt_req_i,
  input logic flag_wr_i,
  input logic flag_wdata_i,
  input logic cold_flag_o,
  input logic sys_rst_o
);
  import rst_seq_pkg::*;

  localparam int unsigned   PW   = width_for(POR_DELAY);
  localparam int unsigned   BW   = width_for(BOD_DELAY);
  localparam int unsigned   WW   = width_for(WDT_PULSE);
  localparam logic [PW-1:0] PLIM = PW'(POR_DELAY);
  localparam logic [BW-1:0] BLIM = BW'(BOD_DELAY);
  localparam logic [WW-1:0] WLIM = WW'(WDT_PULSE);

  logic [PW-1:0] por_seen;
  logic [BW-1:0] bod_seen;
  logic [WW-1:0] wdt_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_seen <= '0;
      bod_seen <= '0;
      wdt_left <= '0;
    end else begin
      if (por_low_i)             por_seen <= '0;
      else if (por_seen != PLIM) por_seen <= por_seen + 1'b1;
      if (bod_low_i)             bod_seen <= '0;
      else if (bod_seen != BLIM) bod_seen <= bod_seen + 1'b1;
      if (wdt_req_i)             wdt_left <= WLIM;
      else if (wdt_left != '0)   wdt_left <= wdt_left - 1'b1;
    end
  end

  AST_POR_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    por_low_i |-> sys_rst_o); // R2
  AST_POR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (por_seen < PLIM) |-> sys_rst_o); // R3
  AST_BOD_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    bod_low_i |-> sys_rst_o); // R4
  AST_BOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bod_seen < BLIM) |-> sys_rst_o); // R5
  AST_WDT_START: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_req_i |=> sys_rst_o); // R8
  AST_WDT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_left != '0) |-> sys_rst_o); // R8
  AST_COLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    por_low_i |=> cold_flag_o); // R9
  AST_COLD_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cold_flag_o) |-> $past(flag_wr_i && !flag_wdata_i && !por_low_i)); // R10
  AST_COLD_RISE_ONLY_POR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cold_flag_o) |-> $past(por_low_i)); // R11

endmodule

bind rst_sequencer rst_sequencer_chk #(
  .POR_DELAY (POR_DELAY),
  .BOD_DELAY (BOD_DELAY),
  .WDT_PULSE (WDT_PULSE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .por_low_i    (por_low_i),
  .bod_low_i    (bod_low_i),
  .wdt_req_i    (wdt_req_i),
  .flag_wr_i    (flag_wr_i),
  .flag_wdata_i (flag_wdata_i),
  .cold_flag_o  (cold_flag_o),
  .sys_rst_o    (sys_rst_o)
);

// File: tb/rst_sequencer_tb_top.sv
`timescale 1ns/1ps
module rst_sequencer_tb_top;

  localparam int unsigned POR_D = 40;
  localparam int unsigned BOD_D = 24;
  localparam int unsigned WDT_P = 16;

  logic clk = 1'b0;
  logic rst_n, por_low, bod_low, pin, wdt_req, fwr, fwd;
  logic cold_flag, sys_rst;
  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;

  always #5 clk = ~clk;

  rst_sequencer #(
    .POR_DELAY (POR_D),
    .BOD_DELAY (BOD_D),
    .EXT_SYNC  (2),
    .EXT_MIN   (2),
    .WDT_PULSE (WDT_P)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .por_low_i     (por_low),
    .bod_low_i     (bod_low),
    .ext_rst_pin_i (pin),
    .wdt_req_i     (wdt_req),
    .flag_wr_i     (fwr),
    .flag_wdata_i  (fwd),
    .cold_flag_o   (cold_flag),
    .sys_rst_o     (sys_rst)
  );

  // Cold-flag vectors: {por_low, flag_wr, flag_wdata, expected flag}
  localparam logic [3:0] FLAG_VEC [7] = '{
    4'b0_1_0_0,  // R10 clear by writing 0
    4'b0_1_1_0,  // R10 writing 1 has no effect
    4'b1_0_0_1,  // R9 power-on sets
    4'b0_1_1_1,  // R10 writing 1 keeps it set
    4'b1_1_0_1,  // R10 set wins over clear
    4'b0_1_0_0,  // R10 clear
    4'b0_0_0_0   // R10 idle holds
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; por_low = 1'b0; bod_low = 1'b0; pin = 1'b0;
    wdt_req = 1'b0; fwr = 1'b0; fwd = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 reset held during rst_n", sys_rst, 1'b1);
    check("R9 flag set by rst_n", cold_flag, 1'b1);
    rst_n = 1'b1;
    repeat (POR_D - 1) tick();
    check("R12 still held one edge before max delay", sys_rst, 1'b1);
    tick();
    check("R12 released at max delay", sys_rst, 1'b0);

    // Vector table for the cold-start flag.
    for (int i = 0; i < 7; i++) begin
      {por_low, fwr, fwd} = FLAG_VEC[i][3:1];
      tick();
      check($sformatf("R10/R9 flag vector %0d", i), cold_flag, FLAG_VEC[i][0]);
    end
    {por_low, fwr, fwd} = 3'b000;
    repeat (60) tick();
    check("R1 idle after all sources inactive", sys_rst, 1'b0);

    // Power-on: immediate assertion and exact release.
    por_low = 1'b1;
    #1 check("R2 immediate on power-on low", sys_rst, 1'b1);
    @(negedge clk);
    repeat (3) tick();
    por_low = 1'b0;
    repeat (POR_D - 1) tick();
    check("R3 held before power-on delay ends", sys_rst, 1'b1);
    tick();
    check("R3 released after power-on delay", sys_rst, 1'b0);
    check("R9 flag set by power-on", cold_flag, 1'b1);
    fwr = 1'b1; fwd = 1'b0;
    tick();
    fwr = 1'b0;
    check("R10 flag cleared", cold_flag, 1'b0);

    // Brown-out: immediate assertion and its own release delay.
    bod_low = 1'b1;
    #1 check("R4 immediate on brown-out low", sys_rst, 1'b1);
    @(negedge clk);
    repeat (2) tick();
    bod_low = 1'b0;
    repeat (BOD_D - 1) tick();
    check("R5 held before brown-out delay ends", sys_rst, 1'b1);
    tick();
    check("R5 released after brown-out delay", sys_rst, 1'b0);
    check("R11 brown-out leaves flag", cold_flag, 1'b0);

    // External pin: one-cycle pulse is ignored.
    pin = 1'b1;
    tick();
    pin = 1'b0;
    for (int k = 0; k < 6; k++) begin
      tick();
      check("R7 short pin pulse ignored", sys_rst, 1'b0);
    end

    // External pin: two-cycle pulse qualifies.
    pin = 1'b1;
    tick(); tick();
    pin = 1'b0;
    tick();
    check("R6 not yet asserted after 3rd edge", sys_rst, 1'b0);
    tick();
    check("R6 asserted after 4th edge", sys_rst, 1'b1);
    tick();
    check("R6 released after two-cycle pulse", sys_rst, 1'b0);

    // External pin: long hold.
    pin = 1'b1;
    repeat (3) tick();
    check("R6 latency on long hold", sys_rst, 1'b0);
    tick();
    check("R6 asserted on long hold", sys_rst, 1'b1);
    repeat (6) tick();
    check("R6 stays asserted while pin high", sys_rst, 1'b1);
    pin = 1'b0;
    tick();
    check("R6 pin low first edge", sys_rst, 1'b1);
    tick();
    check("R6 pin low second edge", sys_rst, 1'b1);
    tick();
    check("R6 released after pin low", sys_rst, 1'b0);
    check("R11 pin leaves flag", cold_flag, 1'b0);

    // Watchdog pulse.
    wdt_req = 1'b1;
    tick();
    wdt_req = 1'b0;
    check("R8 watchdog pulse starts", sys_rst, 1'b1);
    repeat (WDT_P - 1) tick();
    check("R8 watchdog pulse last cycle", sys_rst, 1'b1);
    tick();
    check("R8 watchdog pulse ends", sys_rst, 1'b0);

    // Watchdog retrigger during the pulse.
    wdt_req = 1'b1;
    tick();
    wdt_req = 1'b0;
    repeat (9) tick();
    wdt_req = 1'b1;
    tick();
    wdt_req = 1'b0;
    repeat (WDT_P - 1) tick();
    check("R8 retrigger extends pulse", sys_rst, 1'b1);
    tick();
    check("R8 retriggered pulse ends", sys_rst, 1'b0);
    check("R11 watchdog leaves flag", cold_flag, 1'b0);

    // Overlap: watchdog expires while the pin is still held.
    pin = 1'b1; wdt_req = 1'b1;
    tick();
    wdt_req = 1'b0;
    repeat (19) tick();
    check("R1 pin keeps reset after watchdog pulse", sys_rst, 1'b1);
    pin = 1'b0;
    repeat (3) tick();
    check("R1 released when last source drops", sys_rst, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule